// File: doc/BRIEF.md
# Event Notification Queue Sequencer

This block handles one trigger aimed at an event descriptor whose fields have already been fetched. The descriptor fields and the event data arrive together with the trigger. All of them are captured in the cycle the trigger is accepted.

If queueing is enabled, the block first writes one word into a circular queue in memory. It then walks a fixed decision sequence:

- a masking test;
- an optional coalescing step on a two-bit notification state pair;
- a request to a presenter, which answers found or not-found;
- on not-found, an optional backlog update of an eight-bit pending bitmap;
- finally, an optional escalation, gated by a second two-bit state pair.

When the sequence ends, the block pulses a completion strobe. Alongside the strobe it presents the updated queue index, generation bits, both state pairs, the pending bitmap and a two-bit outcome code. The surrounding logic writes these values back to the descriptor and the target record.

Escalation does not recurse inside the block. It leaves as a new trigger request carrying a block, an index and a data word. Every transfer uses a valid/ready handshake, and only one trigger is in flight at a time.

Top module: `evq_sequencer`

## Requirements
- R1: The queue holds 2^(qsize+10) entries. The write index advances modulo that count, so an index one below the count returns to 0, while the same index under a larger qsize simply increments.
- R2: An enqueue write goes to address qbase + 4*index. The written word carries the current generation bit in bit 31 and bits 30..0 of the event data.
- R3: After each enqueue the index increments. On a wrap to 0 the generation bit inverts and the generation-flipped flag takes the new generation value. With queueing disabled, no write is issued and index, generation and flag are returned unchanged.
- R4: With the silent flag set, no presenter request is made and processing moves directly to the escalation step.
- R5: With format 0 and priority 0xFF the event is masked. There is no presenter request, no escalation, and the outcome is 0 (stop).
- R6: State pairs are encoded as {P,Q} with P in bit 1. A pair trigger maps 00 to 10 and notifies, maps 10 and 11 to 11, and leaves 01 at 01; only the first case notifies. When the always-notify flag is clear, the notification pair is triggered, and a non-notifying trigger ends processing with outcome 0. When the flag is set, the pair is returned unchanged.
- R7: A found answer from the presenter ends processing with outcome 1 (notified), and no escalation follows.
- R8: On not-found with backlog enabled and format 0, bit (7 - priority) of the pending bitmap is set for priorities 0..7. Priorities above 7 leave the bitmap unchanged. In both cases the outcome is 2 (backlog) unless escalation follows.
- R9: On not-found with backlog enabled and format 1, the event is dropped. The bitmap is unchanged, there is no escalation, and the outcome is 0.
- R10: Escalation requires the escalate flag. Unless the unconditional flag is set, it also requires a notifying trigger of the escalation pair. It then issues one request carrying the descriptor's escalation block, index and data, and ends with outcome 3. A skipped escalation leaves the escalation pair untouched.
- R11: Each request holds valid with a stable payload until ready. trig_ready is high only while no other request is pending. done_valid is a one-cycle pulse, and after reset the block is idle with trig_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_valid | input | 1 | Trigger offered |
| trig_ready | output | 1 | Block idle, trigger accepted |
| trig_data | input | DATA_W | Event data |
| d_enqueue | input | 1 | Queueing enabled |
| d_qbase | input | ADDR_W | Queue base address |
| d_qsize | input | QSIZE_W | Queue size code |
| d_qidx | input | IDX_W | Current write index |
| d_gen | input | 1 | Generation bit |
| d_gflip | input | 1 | Generation-flipped flag |
| d_silent | input | 1 | Skip notification |
| d_fmt | input | 1 | Notification format |
| d_prio | input | 8 | Priority |
| d_always | input | 1 | Always notify (bypass notification pair) |
| d_backlog | input | 1 | Backlog enabled |
| d_escalate | input | 1 | Escalation enabled |
| d_uncond | input | 1 | Unconditional escalation |
| d_ns | input | 2 | Notification state pair |
| d_es | input | 2 | Escalation state pair |
| d_tgt | input | TGT_W | Target identifier |
| d_esc_blk | input | BLK_W | Escalation block |
| d_esc_idx | input | EIDX_W | Escalation index |
| d_esc_data | input | DATA_W | Escalation data |
| d_pend | input | 8 | Target pending bitmap |
| mem_valid | output | 1 | Queue write request |
| mem_ready | input | 1 | Queue write accepted |
| mem_addr | output | ADDR_W | Queue write address |
| mem_data | output | DATA_W | Queue write word |
| pres_valid | output | 1 | Presenter request |
| pres_ready | input | 1 | Presenter request accepted |
| pres_fmt | output | 1 | Request format |
| pres_prio | output | 8 | Request priority |
| pres_tgt | output | TGT_W | Request target |
| pres_rsp_valid | input | 1 | Presenter answer strobe |
| pres_found | input | 1 | Presenter found a match |
| esc_valid | output | 1 | Escalation trigger request |
| esc_ready | input | 1 | Escalation accepted |
| esc_blk | output | BLK_W | Escalation block |
| esc_idx | output | EIDX_W | Escalation index |
| esc_data | output | DATA_W | Escalation data |
| done_valid | output | 1 | Completion pulse |
| done_outcome | output | 2 | 0 stop, 1 notified, 2 backlog, 3 escalated |
| done_qidx | output | IDX_W | Updated index |
| done_gen | output | 1 | Updated generation bit |
| done_gflip | output | 1 | Updated generation-flipped flag |
| done_ns | output | 2 | Updated notification pair |
| done_es | output | 2 | Updated escalation pair |
| done_pend | output | 8 | Updated pending bitmap |

## Verification
The bench exercises the corner cases below and names the failure each would expose:

- Index wrap at the smallest queue size, and the same index under a larger size. A wrong entry count would wrap early or never invert the generation.
- Generation flip from 1 back to 0. A design that sets the flipped flag to 1 instead of the new generation would show here.
- Every state-pair value on both the notification and escalation paths. A wrong transition would notify twice or drop the 01 hold.
- Masked and format-1 priority 0xFF events, plus silent escalation. A design that ignores these would reach the presenter.
- Format-1 backlog and a priority above 7. A design that mishandles them would corrupt the pending bitmap or escalate a dropped event.
- Ready lines that toggle every cycle. These catch a request that drops or changes its payload before acceptance.

// File: rtl/evq_pkg.sv
// Shared types for the event queue sequencer: outcome codes, FSM states,
// and constants fixed by the descriptor layout.
package evq_pkg;

    localparam int PEND_W     = 8;   // pending bitmap width, one bit per priority 0..7
    localparam int QSIZE_BASE = 10;  // entries = 2^(qsize + QSIZE_BASE)

    typedef enum logic [1:0] {
        OUT_STOP      = 2'd0,
        OUT_NOTIFIED  = 2'd1,
        OUT_BACKLOG   = 2'd2,
        OUT_ESCALATED = 2'd3
    } evq_outcome_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ENQ,
        S_NOTE,
        S_PRES,
        S_WAIT,
        S_ESC_CHK,
        S_ESC,
        S_DONE
    } evq_state_e;

endpackage

// File: rtl/evq_pair_trigger.sv
// Two-bit coalescing state pair {P,Q}: computes the next state and whether
// a trigger in the current state produces a notification.
// Assumes: purely combinational, the caller decides when to commit.
module evq_pair_trigger (
    input  logic [1:0] pq_in,
    output logic [1:0] pq_out,
    output logic       fire
);
    // Next-state table: 00 -> 10 fires, 01 holds, 10/11 -> 11
    always_comb begin
        fire = 1'b0;
        case (pq_in)
            2'b00:   begin pq_out = 2'b10; fire = 1'b1; end
            2'b01:   pq_out = 2'b01;
            default: pq_out = 2'b11;
        endcase
    end
endmodule

// File: rtl/evq_ring_step.sv
// Circular queue arithmetic: write address and word for the current slot,
// and the index and generation values after the write.
// Assumes: ADDR_W > IDX_W + 2; qsize codes beyond IDX_W use the full index.
module evq_ring_step #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 16,
    parameter int QSIZE_W = 4
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [QSIZE_W-1:0] qsize,
    input  logic [IDX_W-1:0]   idx,
    input  logic               gen,
    input  logic               gflip,
    input  logic [DATA_W-1:0]  evt_data,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_word,
    output logic [IDX_W-1:0]   nxt_idx,
    output logic               nxt_gen,
    output logic               nxt_gflip
);
    import evq_pkg::*;

    localparam logic [DATA_W-1:0] LOW_MASK = {1'b0, {(DATA_W-1){1'b1}}};

    logic [IDX_W-1:0] mask;
    int               shamt;
    logic             wrap;

    // Entry-count mask derived from the size code
    always_comb begin
        shamt = int'(qsize) + QSIZE_BASE;
        if (shamt >= IDX_W) mask = '1;
        else                mask = (IDX_W'(1) << shamt) - IDX_W'(1);
    end

    // Slot address and stored word
    assign wr_addr = base + (ADDR_W'(idx) << 2);
    assign wr_word = {gen, {(DATA_W-1){1'b0}}} | (evt_data & LOW_MASK);

    // Index advance with generation toggle on wrap
    assign nxt_idx   = (idx + IDX_W'(1)) & mask;
    assign wrap      = (nxt_idx == '0);
    assign nxt_gen   = wrap ? ~gen : gen;
    assign nxt_gflip = wrap ? nxt_gen : gflip;
endmodule

// File: rtl/evq_sequencer.sv
// Event notification queue sequencer: serialises one trigger at a time
// through enqueue, masking, notification coalescing, presenter lookup,
// backlog and escalation, and returns the updated descriptor state.
// Assumes: descriptor inputs are valid together with trig_valid; the
// presenter answers with a one-cycle pres_rsp_valid after its request.
module evq_sequencer #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 16,
    parameter int QSIZE_W = 4,
    parameter int BLK_W   = 4,
    parameter int EIDX_W  = 24,
    parameter int TGT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_valid,
    output logic               trig_ready,
    input  logic [DATA_W-1:0]  trig_data,
    input  logic               d_enqueue,
    input  logic [ADDR_W-1:0]  d_qbase,
    input  logic [QSIZE_W-1:0] d_qsize,
    input  logic [IDX_W-1:0]   d_qidx,
    input  logic               d_gen,
    input  logic               d_gflip,
    input  logic               d_silent,
    input  logic               d_fmt,
    input  logic [7:0]         d_prio,
    input  logic               d_always,
    input  logic               d_backlog,
    input  logic               d_escalate,
    input  logic               d_uncond,
    input  logic [1:0]         d_ns,
    input  logic [1:0]         d_es,
    input  logic [TGT_W-1:0]   d_tgt,
    input  logic [BLK_W-1:0]   d_esc_blk,
    input  logic [EIDX_W-1:0]  d_esc_idx,
    input  logic [DATA_W-1:0]  d_esc_data,
    input  logic [7:0]         d_pend,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_data,
    output logic               pres_valid,
    input  logic               pres_ready,
    output logic               pres_fmt,
    output logic [7:0]         pres_prio,
    output logic [TGT_W-1:0]   pres_tgt,
    input  logic               pres_rsp_valid,
    input  logic               pres_found,
    output logic               esc_valid,
    input  logic               esc_ready,
    output logic [BLK_W-1:0]   esc_blk,
    output logic [EIDX_W-1:0]  esc_idx,
    output logic [DATA_W-1:0]  esc_data,
    output logic               done_valid,
    output logic [1:0]         done_outcome,
    output logic [IDX_W-1:0]   done_qidx,
    output logic               done_gen,
    output logic               done_gflip,
    output logic [1:0]         done_ns,
    output logic [1:0]         done_es,
    output logic [7:0]         done_pend
);
    import evq_pkg::*;

    localparam int NPAIR = 2;   // index 0: notification pair, 1: escalation pair

    evq_state_e         state;
    evq_outcome_e       r_out;
    logic [DATA_W-1:0]  r_data;
    logic [ADDR_W-1:0]  r_qbase;
    logic [QSIZE_W-1:0] r_qsize;
    logic [IDX_W-1:0]   r_qidx;
    logic               r_gen, r_gflip;
    logic               r_enq, r_silent, r_fmt, r_always, r_backlog, r_escalate, r_uncond;
    logic [7:0]         r_prio;
    logic [1:0]         r_ns, r_es;
    logic [TGT_W-1:0]   r_tgt;
    logic [BLK_W-1:0]   r_esc_blk;
    logic [EIDX_W-1:0]  r_esc_idx;
    logic [DATA_W-1:0]  r_esc_data;
    logic [PEND_W-1:0]  r_pend;

    logic [IDX_W-1:0]   nxt_idx;
    logic               nxt_gen, nxt_gflip;
    logic [NPAIR-1:0][1:0] pair_cur, pair_nxt;
    logic [NPAIR-1:0]      pair_fire;
    logic               masked;
    logic [PEND_W-1:0]  prio_bit;

    // Queue slot arithmetic on the captured descriptor
    evq_ring_step #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .QSIZE_W(QSIZE_W)
    ) u_ring (
        .base     (r_qbase),
        .qsize    (r_qsize),
        .idx      (r_qidx),
        .gen      (r_gen),
        .gflip    (r_gflip),
        .evt_data (r_data),
        .wr_addr  (mem_addr),
        .wr_word  (mem_data),
        .nxt_idx  (nxt_idx),
        .nxt_gen  (nxt_gen),
        .nxt_gflip(nxt_gflip)
    );

    assign pair_cur[0] = r_ns;
    assign pair_cur[1] = r_es;

    // One coalescing pair per event-state buffer
    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        evq_pair_trigger u_pair (
            .pq_in (pair_cur[g]),
            .pq_out(pair_nxt[g]),
            .fire  (pair_fire[g])
        );
    end

    // Masking test and pending-bit selection
    assign masked   = !r_fmt && (r_prio == 8'hFF);
    assign prio_bit = (r_prio < 8'd8) ? (8'h80 >> r_prio[2:0]) : 8'h00;

    // Sequencer FSM: one trigger from capture to completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            r_out      <= OUT_STOP;
            done_valid <= 1'b0;
            r_data     <= '0;
            r_qbase    <= '0;
            r_qsize    <= '0;
            r_qidx     <= '0;
            r_gen      <= 1'b0;
            r_gflip    <= 1'b0;
            r_enq      <= 1'b0;
            r_silent   <= 1'b0;
            r_fmt      <= 1'b0;
            r_always   <= 1'b0;
            r_backlog  <= 1'b0;
            r_escalate <= 1'b0;
            r_uncond   <= 1'b0;
            r_prio     <= '0;
            r_ns       <= '0;
            r_es       <= '0;
            r_tgt      <= '0;
            r_esc_blk  <= '0;
            r_esc_idx  <= '0;
            r_esc_data <= '0;
            r_pend     <= '0;
        end else begin
            done_valid <= 1'b0;
            case (state)
                S_IDLE: if (trig_valid) begin
                    r_data     <= trig_data;
                    r_qbase    <= d_qbase;
                    r_qsize    <= d_qsize;
                    r_qidx     <= d_qidx;
                    r_gen      <= d_gen;
                    r_gflip    <= d_gflip;
                    r_enq      <= d_enqueue;
                    r_silent   <= d_silent;
                    r_fmt      <= d_fmt;
                    r_always   <= d_always;
                    r_backlog  <= d_backlog;
                    r_escalate <= d_escalate;
                    r_uncond   <= d_uncond;
                    r_prio     <= d_prio;
                    r_ns       <= d_ns;
                    r_es       <= d_es;
                    r_tgt      <= d_tgt;
                    r_esc_blk  <= d_esc_blk;
                    r_esc_idx  <= d_esc_idx;
                    r_esc_data <= d_esc_data;
                    r_pend     <= d_pend;
                    r_out      <= OUT_STOP;
                    if (d_enqueue)     state <= S_ENQ;
                    else if (d_silent) state <= S_ESC_CHK;
                    else               state <= S_NOTE;
                end
                S_ENQ: if (mem_ready) begin
                    r_qidx  <= nxt_idx;
                    r_gen   <= nxt_gen;
                    r_gflip <= nxt_gflip;
                    state   <= r_silent ? S_ESC_CHK : S_NOTE;
                end
                S_NOTE: begin
                    if (masked) begin
                        state <= S_DONE;
                    end else if (!r_always) begin
                        r_ns  <= pair_nxt[0];
                        state <= pair_fire[0] ? S_PRES : S_DONE;
                    end else begin
                        state <= S_PRES;
                    end
                end
                S_PRES: if (pres_ready) state <= S_WAIT;
                S_WAIT: if (pres_rsp_valid) begin
                    if (pres_found) begin
                        r_out <= OUT_NOTIFIED;
                        state <= S_DONE;
                    end else if (r_backlog && r_fmt) begin
                        state <= S_DONE;
                    end else begin
                        if (r_backlog) begin
                            r_pend <= r_pend | prio_bit;
                            r_out  <= OUT_BACKLOG;
                        end
                        state <= S_ESC_CHK;
                    end
                end
                S_ESC_CHK: begin
                    if (!r_escalate) begin
                        state <= S_DONE;
                    end else if (!r_uncond) begin
                        r_es  <= pair_nxt[1];
                        state <= pair_fire[1] ? S_ESC : S_DONE;
                    end else begin
                        state <= S_ESC;
                    end
                end
                S_ESC: if (esc_ready) begin
                    r_out <= OUT_ESCALATED;
                    state <= S_DONE;
                end
                default: begin
                    done_valid <= 1'b1;
                    state      <= S_IDLE;
                end
            endcase
        end
    end

    // Handshake outputs decoded from the FSM state
    assign trig_ready = (state == S_IDLE);
    assign mem_valid  = (state == S_ENQ);
    assign pres_valid = (state == S_PRES);
    assign esc_valid  = (state == S_ESC);

    // Request payloads and returned descriptor state
    assign pres_fmt     = r_fmt;
    assign pres_prio    = r_prio;
    assign pres_tgt     = r_tgt;
    assign esc_blk      = r_esc_blk;
    assign esc_idx      = r_esc_idx;
    assign esc_data     = r_esc_data;
    assign done_outcome = r_out;
    assign done_qidx    = r_qidx;
    assign done_gen     = r_gen;
    assign done_gflip   = r_gflip;
    assign done_ns      = r_ns;
    assign done_es      = r_es;
    assign done_pend    = r_pend;
endmodule

// File: rtl/evq_sequencer_chk.sv
// Protocol checker for evq_sequencer: handshake stability, exclusive
// request phases and the completion pulse shape.
module evq_sequencer_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BLK_W  = 4,
    parameter int EIDX_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              pres_valid,
    input logic              pres_ready,
    input logic              esc_valid,
    input logic              esc_ready,
    input logic [BLK_W-1:0]  esc_blk,
    input logic [EIDX_W-1:0] esc_idx,
    input logic [DATA_W-1:0] esc_data,
    input logic              done_valid
);
    // Queue write holds until accepted (R2)
    assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    // Presenter request holds until accepted (R11)
    assert_pres_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid && !pres_ready |=> pres_valid);

    // Escalation request holds its payload until accepted (R10)
    assert_esc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        esc_valid && !esc_ready |=> esc_valid && $stable(esc_blk) && $stable(esc_idx) && $stable(esc_data));

    // At most one of idle or a pending request at any time (R11)
    assert_one_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trig_ready, mem_valid, pres_valid, esc_valid}));

    // Completion strobe lasts one cycle (R11)
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);
endmodule

bind evq_sequencer evq_sequencer_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .BLK_W (BLK_W),
    .EIDX_W(EIDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_ready(trig_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .pres_valid(pres_valid),
    .pres_ready(pres_ready),
    .esc_valid (esc_valid),
    .esc_ready (esc_ready),
    .esc_blk   (esc_blk),
    .esc_idx   (esc_idx),
    .esc_data  (esc_data),
    .done_valid(done_valid)
);

// File: tb/evq_sequencer_tb.sv
// Scoreboard bench: the driver computes the expected result of each trigger
// from the requirements and queues it; the monitor compares on completion.
module evq_sequencer_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic        trig_valid = 1'b0;
    logic        trig_ready;
    logic [31:0] trig_data = '0;
    logic        d_enqueue = 0, d_gen = 0, d_gflip = 0, d_silent = 0, d_fmt = 0;
    logic        d_always = 0, d_backlog = 0, d_escalate = 0, d_uncond = 0;
    logic [31:0] d_qbase = '0;
    logic [3:0]  d_qsize = '0;
    logic [15:0] d_qidx = '0;
    logic [7:0]  d_prio = '0, d_pend = '0;
    logic [1:0]  d_ns = '0, d_es = '0;
    logic [15:0] d_tgt = 16'h0042;
    logic [3:0]  d_esc_blk = 4'hA;
    logic [23:0] d_esc_idx = 24'h00BEEF;
    logic [31:0] d_esc_data = 32'hCAFE0001;
    logic        mem_valid, pres_valid, esc_valid, done_valid;
    logic        mem_ready = 1'b1, pres_ready = 1'b1, esc_ready = 1'b1;
    logic [31:0] mem_addr, mem_data, esc_data;
    logic        pres_fmt;
    logic [7:0]  pres_prio, done_pend;
    logic [15:0] pres_tgt, done_qidx;
    logic        pres_rsp_valid = 1'b0, pres_found = 1'b0;
    logic [3:0]  esc_blk;
    logic [23:0] esc_idx;
    logic [1:0]  done_outcome, done_ns, done_es;
    logic        done_gen, done_gflip;

    evq_sequencer u_dut (
        .clk(clk), .rst_n(rst_n),
        .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_data(trig_data),
        .d_enqueue(d_enqueue), .d_qbase(d_qbase), .d_qsize(d_qsize), .d_qidx(d_qidx),
        .d_gen(d_gen), .d_gflip(d_gflip), .d_silent(d_silent), .d_fmt(d_fmt),
        .d_prio(d_prio), .d_always(d_always), .d_backlog(d_backlog),
        .d_escalate(d_escalate), .d_uncond(d_uncond), .d_ns(d_ns), .d_es(d_es),
        .d_tgt(d_tgt), .d_esc_blk(d_esc_blk), .d_esc_idx(d_esc_idx),
        .d_esc_data(d_esc_data), .d_pend(d_pend),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .pres_valid(pres_valid), .pres_ready(pres_ready), .pres_fmt(pres_fmt),
        .pres_prio(pres_prio), .pres_tgt(pres_tgt),
        .pres_rsp_valid(pres_rsp_valid), .pres_found(pres_found),
        .esc_valid(esc_valid), .esc_ready(esc_ready), .esc_blk(esc_blk),
        .esc_idx(esc_idx), .esc_data(esc_data),
        .done_valid(done_valid), .done_outcome(done_outcome), .done_qidx(done_qidx),
        .done_gen(done_gen), .done_gflip(done_gflip), .done_ns(done_ns),
        .done_es(done_es), .done_pend(done_pend)
    );

    typedef struct {
        logic enq, gen, gf, silent, fmt, always_n, backlog, escalate, uncond, found;
        logic [31:0] base, data;
        logic [3:0]  qsize;
        logic [15:0] qidx;
        logic [7:0]  prio, pend;
        logic [1:0]  ns, es;
    } stim_t;

    typedef struct {
        string       tag;
        logic [1:0]  outcome;
        logic [15:0] qidx;
        logic        gen, gf;
        logic [1:0]  ns, es;
        logic [7:0]  pend;
        int          n_mem, n_pres, n_esc;
        logic [31:0] addr, word;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0, n_fail = 0;
    int   m_cnt = 0, p_cnt = 0, e_cnt = 0;
    logic [31:0] m_addr = '0, m_word = '0;
    logic answer = 1'b0;
    logic stall = 1'b0;
    logic finished = 1'b0;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Pair trigger per R6: returns {notify, next}
    function automatic logic [2:0] pair_step(logic [1:0] s);
        case (s)
            2'b00:   return {1'b1, 2'b10};
            2'b01:   return {1'b0, 2'b01};
            default: return {1'b0, 2'b11};
        endcase
    endfunction

    function automatic exp_t model(stim_t s, string tag);
        exp_t e;
        logic stop;
        logic [2:0] t;
        int entries;
        e.tag = tag; e.outcome = 2'd0; e.qidx = s.qidx; e.gen = s.gen; e.gf = s.gf;
        e.ns = s.ns; e.es = s.es; e.pend = s.pend;
        e.n_mem = 0; e.n_pres = 0; e.n_esc = 0; e.addr = '0; e.word = '0;
        stop = 1'b0;
        if (s.enq) begin
            entries = 1 << (int'(s.qsize) + 10);
            e.n_mem = 1;
            e.addr = s.base + 32'(s.qidx) * 4;
            e.word = {s.gen, s.data[30:0]};
            e.qidx = 16'((int'(s.qidx) + 1) % entries);
            if (e.qidx == 0) begin e.gen = ~s.gen; e.gf = e.gen; end
        end
        if (!s.silent) begin
            if (!s.fmt && s.prio == 8'hFF) stop = 1'b1;
            if (!stop && !s.always_n) begin
                t = pair_step(s.ns); e.ns = t[1:0];
                if (!t[2]) stop = 1'b1;
            end
            if (!stop) begin
                e.n_pres = 1;
                if (s.found) begin e.outcome = 2'd1; stop = 1'b1; end
                else if (s.backlog && s.fmt) stop = 1'b1;
                else if (s.backlog) begin
                    if (s.prio < 8) e.pend = s.pend | (8'h80 >> s.prio[2:0]);
                    e.outcome = 2'd2;
                end
            end
        end
        if (!stop && s.escalate) begin
            if (!s.uncond) begin
                t = pair_step(s.es); e.es = t[1:0];
                if (!t[2]) stop = 1'b1;
            end
            if (!stop) begin e.n_esc = 1; e.outcome = 2'd3; end
        end
        return e;
    endfunction

    function automatic stim_t base_stim();
        stim_t s;
        s.enq = 0; s.gen = 0; s.gf = 0; s.silent = 0; s.fmt = 0; s.always_n = 1;
        s.backlog = 0; s.escalate = 0; s.uncond = 0; s.found = 1;
        s.base = 32'h0001_0000; s.data = 32'h1234_5678; s.qsize = 0; s.qidx = 0;
        s.prio = 8'd3; s.pend = 8'h00; s.ns = 2'b00; s.es = 2'b00;
        return s;
    endfunction

    // Driver: push the expected result, offer the trigger, wait for completion
    task automatic run(stim_t s, string tag);
        sb.push_back(model(s, tag));
        @(negedge clk);
        answer = s.found;
        trig_data = s.data; d_enqueue = s.enq; d_qbase = s.base; d_qsize = s.qsize;
        d_qidx = s.qidx; d_gen = s.gen; d_gflip = s.gf; d_silent = s.silent; d_fmt = s.fmt;
        d_prio = s.prio; d_always = s.always_n; d_backlog = s.backlog;
        d_escalate = s.escalate; d_uncond = s.uncond; d_ns = s.ns; d_es = s.es; d_pend = s.pend;
        trig_valid = 1'b1;
        @(negedge clk);
        trig_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    // Presenter model: answers one cycle after each accepted request
    always @(posedge clk) begin
        pres_rsp_valid <= pres_valid && pres_ready;
        pres_found     <= answer;
    end

    // Ready toggling while stall mode is on
    always @(posedge clk) begin
        if (stall) begin mem_ready <= ~mem_ready; esc_ready <= ~esc_ready; end
        else begin mem_ready <= 1'b1; esc_ready <= 1'b1; end
    end

    // Monitor: tally transfers and compare each completion with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_valid && mem_ready) begin m_cnt++; m_addr = mem_addr; m_word = mem_data; end
            if (pres_valid && pres_ready) begin
                p_cnt++;
                chk("R7", "presenter target", 64'(pres_tgt), 64'h42);
            end
            if (esc_valid && esc_ready) begin
                e_cnt++;
                chk("R10", "escalation payload", {esc_blk, esc_idx, esc_data},
                    {4'hA, 24'h00BEEF, 32'hCAFE0001});
            end
            if (done_valid) begin
                if (sb.size() == 0) begin
                    chk("R11", "unexpected completion", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.tag, "outcome", 64'(done_outcome), 64'(e.outcome));
                    chk(e.tag, "index", 64'(done_qidx), 64'(e.qidx));
                    chk(e.tag, "generation", 64'(done_gen), 64'(e.gen));
                    chk(e.tag, "gen flipped", 64'(done_gflip), 64'(e.gf));
                    chk(e.tag, "notify pair", 64'(done_ns), 64'(e.ns));
                    chk(e.tag, "escalate pair", 64'(done_es), 64'(e.es));
                    chk(e.tag, "pending bitmap", 64'(done_pend), 64'(e.pend));
                    chk(e.tag, "queue writes", 64'(m_cnt), 64'(e.n_mem));
                    chk(e.tag, "presenter requests", 64'(p_cnt), 64'(e.n_pres));
                    chk(e.tag, "escalations", 64'(e_cnt), 64'(e.n_esc));
                    if (e.n_mem == 1 && m_cnt == 1) begin
                        chk(e.tag, "write address", 64'(m_addr), 64'(e.addr));
                        chk(e.tag, "write word", 64'(m_word), 64'(e.word));
                    end
                end
                m_cnt = 0; p_cnt = 0; e_cnt = 0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        stim_t s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: idle after reset
        chk("R11", "reset trig_ready", 64'(trig_ready), 64'd1);
        chk("R11", "reset requests", 64'({mem_valid, pres_valid, esc_valid, done_valid}), 64'd0);

        // R2: plain enqueue, data bit 31 replaced by generation
        s = base_stim(); s.enq = 1; s.qidx = 16'd5; s.data = 32'hFFFF_1234; s.gen = 0;
        run(s, "R2");
        s.gen = 1; s.qidx = 16'd77;
        run(s, "R2");
        // R1/R3: wrap at 1024 entries, generation 0 -> 1
        s = base_stim(); s.enq = 1; s.qidx = 16'd1023; s.gen = 0; s.gf = 0;
        run(s, "R1");
        // R1: same index with qsize 2 does not wrap
        s.qsize = 4'd2;
        run(s, "R1");
        // R3: wrap at 4096 entries, generation 1 -> 0 clears flipped flag
        s.qidx = 16'd4095; s.gen = 1; s.gf = 1;
        run(s, "R3");
        // R3: no enqueue leaves index untouched
        s = base_stim(); s.enq = 0; s.qidx = 16'd9; s.gen = 1;
        run(s, "R3");
        // R5: masked event
        s = base_stim(); s.prio = 8'hFF; s.escalate = 1; s.uncond = 1;
        run(s, "R5");
        // R5: format 1 with priority 0xFF is not masked
        s = base_stim(); s.fmt = 1; s.prio = 8'hFF;
        run(s, "R5");
        // R6: all notification pair states
        for (int k = 0; k < 4; k++) begin
            s = base_stim(); s.always_n = 0; s.ns = 2'(k);
            run(s, "R6");
        end
        // R4: silent with unconditional escalation
        s = base_stim(); s.silent = 1; s.escalate = 1; s.uncond = 1; s.es = 2'b10;
        run(s, "R4");
        // R4: silent with escalation disabled
        s = base_stim(); s.silent = 1; s.enq = 1;
        run(s, "R4");
        // R8: backlog of priority 2 then priority 0 and 7
        s = base_stim(); s.found = 0; s.backlog = 1; s.prio = 8'd2; s.pend = 8'h01;
        run(s, "R8");
        s.prio = 8'd0; s.pend = 8'h00;
        run(s, "R8");
        s.prio = 8'd7;
        run(s, "R8");
        // R8: priority above 7 leaves bitmap alone
        s.prio = 8'd9; s.pend = 8'h5A;
        run(s, "R8");
        // R9: format 1 with backlog dropped, even with escalation enabled
        s = base_stim(); s.found = 0; s.backlog = 1; s.fmt = 1; s.escalate = 1; s.uncond = 1;
        s.pend = 8'h11;
        run(s, "R9");
        // R7: found blocks escalation
        s = base_stim(); s.escalate = 1; s.uncond = 1;
        run(s, "R7");
        // R10: conditional escalation over all pair states, backlog also hit
        for (int k = 0; k < 4; k++) begin
            s = base_stim(); s.found = 0; s.backlog = 1; s.escalate = 1; s.es = 2'(k);
            run(s, "R10");
        end
        // R10: escalation disabled keeps the pair
        s = base_stim(); s.found = 0; s.es = 2'b00;
        run(s, "R10");
        // R11: toggling ready lines
        stall = 1'b1;
        s = base_stim(); s.enq = 1; s.qidx = 16'd1023; s.found = 0; s.escalate = 1; s.uncond = 1;
        run(s, "R11");
        s.qidx = 16'd3; s.es = 2'b00; s.uncond = 0;
        run(s, "R11");
        stall = 1'b0;
        repeat (4) @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule